// File: doc/BRIEF.md
# Mode-Switchable Serial Receive Queue

This block is the receive byte queue behind the data register of a 16550-style serial port. It runs in one of two modes. In holding-register mode it keeps a single byte. In FIFO mode it keeps up to 256 bytes. A configuration write picks the mode. Any write that changes the mode empties the queue. A receiver-clear command given while FIFO mode is on also empties it and keeps the large capacity.

Bytes enter from one of two sources, chosen by the loopback control. With loopback off, the serial receiver pushes bytes over a valid/ready handshake. While the queue holds its full capacity, `rx_ready_o` stays low and the receiver must hold its byte until ready rises. With loopback on, each transmit-register write is pushed into the queue. Bytes that arrive from the serial receiver in that mode are accepted and thrown away. A loopback write that finds the queue full is dropped, and the block raises a one-cycle overrun pulse that the line-status logic latches.

The read side is a valid/ready stream. The head byte is always shown on `out_data_o`, and a byte is popped on any cycle where `out_valid_o` and `out_ready_i` are both high. When the queue is empty, the data output reads 0xFF and a read request changes nothing. The block also reports the count, a not-empty flag and a full flag. The full flag is measured against the current capacity.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty (count 0, `not_empty_o` 0, `full_o` 0, `rx_ready_o` 1), holding-register mode is active, and `out_data_o` reads 0xFF.
- R2: In holding-register mode one stored byte makes `full_o` 1 and `rx_ready_o` 0. A serial push offered while full is not taken, and the stored byte is unchanged.
- R3: In FIFO mode the queue accepts 256 bytes and returns them in arrival order. `full_o` is 1 exactly when the count is 256, and a further push is refused.
- R4: A configuration write whose enable bit differs from the current mode empties the queue at the next clock edge and installs the new capacity. A write with the same enable bit and no clear command leaves the contents alone.
- R5: A configuration write with enable 1 and the clear bit set, while FIFO mode is on, empties the queue and keeps 256-entry capacity. The clear bit has no effect while the enable bit written is 0.
- R6: When the queue is empty, `out_data_o` reads 0xFF and `out_valid_o` is 0. A read request in that state leaves the queue pointers unchanged, so a later byte is still read back correctly.
- R7: A push and a pop accepted in the same cycle leave the count unchanged.
- R8: With `loopback_i` 1, each `tx_wr_i` pulse pushes `tx_data_i`. Serial bytes are accepted (`rx_ready_o` 1) but not stored.
- R9: With `loopback_i` 1, a `tx_wr_i` pulse that arrives while the queue is full is dropped and raises `overrun_o` for exactly the following cycle. A serial push refused while full, with loopback off, raises no overrun.
- R10: With `loopback_i` 0, `tx_wr_i` pulses do not change the queue.
- R11: A flushing configuration write takes priority over a push or pop in the same cycle. The queue is empty afterwards.
- R12: Read and write positions wrap at the current capacity, so arrival order is kept across the 256-entry boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_fifo_en_i | input | 1 | Written mode: 1 selects FIFO mode, 0 selects holding-register mode |
| cfg_rx_clear_i | input | 1 | Written receiver-clear command |
| loopback_i | input | 1 | Loopback mode select |
| rx_valid_i | input | 1 | Serial receiver byte valid |
| rx_data_i | input | 8 | Serial receiver byte |
| rx_ready_o | output | 1 | Queue can take a serial byte |
| tx_wr_i | input | 1 | Transmit-register write strobe |
| tx_data_i | input | 8 | Transmit-register write data |
| out_valid_o | output | 1 | Head byte is valid |
| out_data_o | output | 8 | Head byte, 0xFF when empty |
| out_ready_i | input | 1 | Data-register read: pop the head |
| count_o | output | 9 | Bytes held |
| not_empty_o | output | 1 | Queue holds at least one byte |
| full_o | output | 1 | Count equals current capacity |
| overrun_o | output | 1 | One-cycle pulse on a dropped loopback write |

## Verification
The hardest state to reach from the ports is wrap-around in FIFO mode. Reaching it means filling the queue all the way to 256, confirming it refuses more, draining it, and then streaming more bytes so both positions cross the storage boundary. The stimulus does exactly that, and it checks order and counts on every byte. A second hard case is a flush, a push and a pop all landing on the same edge. The bench drives all three in one cycle to show the flush wins. The overrun pulse is reached by filling the one-entry queue in loopback and then writing again.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DEPTH_DEF  = 256;
  localparam int unsigned RXQ_DATA_W_DEF = 8;

  typedef enum logic {
    SRC_SERIAL   = 1'b0,
    SRC_LOOPBACK = 1'b1
  } rxq_src_e;
endpackage

// File: rtl/rxq_mode_ctrl.sv
module rxq_mode_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic             cfg_fifo_en_i,
  input  logic             cfg_rx_clear_i,
  output logic             fifo_en_o,
  output logic             flush_o,
  output logic [CNT_W-1:0] cap_o
);
  logic fifo_en_q;

  // A mode change, or a clear command with FIFO mode written on, empties the queue
  always_comb begin
    flush_o = 1'b0;
    if (cfg_wr_i) begin
      if (cfg_fifo_en_i != fifo_en_q) flush_o = 1'b1;
      else if (cfg_fifo_en_i && cfg_rx_clear_i) flush_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_en_q <= 1'b0;
    else if (cfg_wr_i) fifo_en_q <= cfg_fifo_en_i;
  end

  assign fifo_en_o = fifo_en_q;
  assign cap_o     = fifo_en_q ? CNT_W'(DEPTH) : CNT_W'(1);

  p_mode_follows_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> (fifo_en_o == $past(cfg_fifo_en_i)));
endmodule

// File: rtl/rxq_src_sel.sv
module rxq_src_sel
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loopback_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              full_i,
  input  logic              flush_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              overrun_o
);
  rxq_src_e src;
  logic     push_req;
  logic     overrun_q;

  assign src = loopback_i ? SRC_LOOPBACK : SRC_SERIAL;

  always_comb begin
    case (src)
      SRC_LOOPBACK: begin
        push_req    = tx_wr_i;
        push_data_o = tx_data_i;
        rx_ready_o  = 1'b1;        // serial bytes are swallowed in loopback
      end
      default: begin
        push_req    = rx_valid_i;
        push_data_o = rx_data_i;
        rx_ready_o  = !full_i;     // back-pressure toward the receiver
      end
    endcase
  end

  assign push_o = push_req && !full_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overrun_q <= 1'b0;
    else overrun_q <= (src == SRC_LOOPBACK) && tx_wr_i && full_i && !flush_i;
  end

  assign overrun_o = overrun_q;

  p_overrun_needs_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(full_i && loopback_i && tx_wr_i));
  p_no_push_when_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> !push_o);
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic             push_i,
  input  logic             pop_req_i,
  output logic             pop_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_pos;

  assign last_pos = cap_i - CNT_W'(1);

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p,
                                                input logic [CNT_W-1:0] last);
    return ({1'b0, p} >= last) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == cap_i);
  assign pop_o   = pop_req_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wrap_inc(wr_q, last_pos);
      if (pop_o)  rd_q <= wrap_inc(rd_q, last_pos);
      case ({push_i, pop_o})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;

  p_count_within_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= cap_i);
  p_flush_empties_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0));
  p_empty_read_keeps_ptr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && empty_o && !flush_i) |=> $stable(rd_ptr_o));
  p_pair_keeps_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_o) |=> $stable(count_o));
  p_ptr_inside_cap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, wr_ptr_o} < cap_i) && ({1'b0, rd_ptr_o} < cap_i));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = RXQ_DEPTH_DEF,
  parameter int unsigned DATA_W = RXQ_DATA_W_DEF,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic              cfg_fifo_en_i,
  input  logic              cfg_rx_clear_i,
  input  logic              loopback_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              not_empty_o,
  output logic              full_o,
  output logic              overrun_o
);
  logic              fifo_en, flush;
  logic [CNT_W-1:0]  cap;
  logic              push, pop;
  logic [DATA_W-1:0] push_data, head;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              full, empty;

  rxq_mode_ctrl #(.DEPTH(DEPTH)) u_mode (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_fifo_en_i, .cfg_rx_clear_i,
    .fifo_en_o(fifo_en), .flush_o(flush), .cap_o(cap)
  );

  rxq_src_sel #(.DATA_W(DATA_W)) u_src (
    .clk_i, .rst_ni, .loopback_i, .rx_valid_i, .rx_data_i, .rx_ready_o,
    .tx_wr_i, .tx_data_i, .full_i(full), .flush_i(flush),
    .push_o(push), .push_data_o(push_data), .overrun_o
  );

  rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i, .rst_ni, .flush_i(flush), .cap_i(cap), .push_i(push),
    .pop_req_i(out_ready_i), .pop_o(pop), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .count_o, .full_o(full), .empty_o(empty)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i, .we_i(push), .waddr_i(wr_ptr), .wdata_i(push_data),
    .raddr_i(rd_ptr), .rdata_o(head)
  );

  assign out_valid_o = !empty;
  assign out_data_o  = empty ? {DATA_W{1'b1}} : head;
  assign not_empty_o = !empty;
  assign full_o      = full;

  p_single_holds_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en |-> (count_o <= CNT_W'(1)));
  p_stall_when_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loopback_i && full_o && !out_ready_i && !cfg_wr_i) |=> full_o);
  p_no_tx_without_loop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loopback_i && !rx_valid_i && !out_ready_i && !cfg_wr_i) |=> $stable(count_o));
  p_pop_consumes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !push && !flush) |=> (count_o == $past(count_o) - CNT_W'(1)));
endmodule

// File: tb/uart_rx_queue_tb_top.sv
`timescale 1ns/1ps
module uart_rx_queue_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 0, cfg_en = 0, cfg_clr = 0, loopback = 0;
  logic       rx_valid = 0, tx_wr = 0, out_ready = 0;
  logic [7:0] rx_data = 0, tx_data = 0;
  logic       rx_ready, out_valid, not_empty, full, overrun;
  logic [7:0] out_data;
  logic [8:0] count;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  uart_rx_queue dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_fifo_en_i(cfg_en),
    .cfg_rx_clear_i(cfg_clr), .loopback_i(loopback), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_ready_o(rx_ready), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .count_o(count), .not_empty_o(not_empty), .full_o(full), .overrun_o(overrun)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_rx(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic push_tx(logic [7:0] b);
    @(negedge clk); tx_wr = 1; tx_data = b;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic pop_chk(string req, logic [7:0] exp);
    @(negedge clk);
    chk(req, "head valid", int'(out_valid), 1);
    chk(req, "head data", int'(out_data), int'(exp));
    out_ready = 1;
    @(negedge clk); out_ready = 0;
  endtask

  task automatic cfg(logic en, logic clr);
    @(negedge clk); cfg_wr = 1; cfg_en = en; cfg_clr = clr;
    @(negedge clk); cfg_wr = 0; cfg_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "count", int'(count), 0);
    chk("R1", "not_empty", int'(not_empty), 0);
    chk("R1", "full", int'(full), 0);
    chk("R1", "rx_ready", int'(rx_ready), 1);
    chk("R1", "empty data", int'(out_data), 255);
  endtask

  task automatic t_single();
    push_rx(8'hA5);
    chk("R1", "count one byte", int'(count), 1);
    chk("R2", "full at one", int'(full), 1);
    chk("R2", "ready low", int'(rx_ready), 0);
    push_rx(8'h3C);
    chk("R2", "count after refused", int'(count), 1);
    pop_chk("R2", 8'hA5);
    chk("R2", "empty after pop", int'(not_empty), 0);
  endtask

  task automatic t_empty_pop();
    @(negedge clk); out_ready = 1;
    chk("R6", "valid when empty", int'(out_valid), 0);
    chk("R6", "data when empty", int'(out_data), 255);
    @(negedge clk); out_ready = 0;
    chk("R6", "count after empty read", int'(count), 0);
    push_rx(8'h11);
    pop_chk("R6", 8'h11);
  endtask

  task automatic t_loop();
    push_tx(8'h66);
    chk("R10", "tx ignored without loopback", int'(count), 0);
    @(negedge clk); loopback = 1;
    push_tx(8'h77);
    chk("R8", "loopback push", int'(count), 1);
    @(negedge clk); rx_valid = 1; rx_data = 8'h99;
    chk("R8", "serial ready in loopback", int'(rx_ready), 1);
    @(negedge clk); rx_valid = 0;
    chk("R8", "serial dropped in loopback", int'(count), 1);
    push_tx(8'h88);
    chk("R9", "overrun pulse", int'(overrun), 1);
    chk("R9", "count after overrun", int'(count), 1);
    @(negedge clk);
    chk("R9", "overrun one cycle", int'(overrun), 0);
    pop_chk("R9", 8'h77);
    @(negedge clk); loopback = 0;
    push_rx(8'h01);
    push_rx(8'h02);
    chk("R9", "no overrun on serial stall", int'(overrun), 0);
    pop_chk("R9", 8'h01);
  endtask

  task automatic t_fifo();
    cfg(1, 0);
    for (int i = 0; i < 256; i++) begin
      push_rx(8'(i ^ 8'h5A));
      if (i == 254) chk("R3", "not full at 255", int'(full), 0);
    end
    chk("R3", "count 256", int'(count), 256);
    chk("R3", "full at 256", int'(full), 1);
    chk("R3", "ready low at 256", int'(rx_ready), 0);
    push_rx(8'hEE);
    chk("R3", "refused at 256", int'(count), 256);
    for (int i = 0; i < 256; i++) pop_chk("R3", 8'(i ^ 8'h5A));
    chk("R3", "drained", int'(count), 0);
    for (int i = 0; i < 40; i++) push_rx(8'(i * 3));
    chk("R12", "count after wrap fill", int'(count), 40);
    for (int i = 0; i < 40; i++) pop_chk("R12", 8'(i * 3));
  endtask

  task automatic t_both();
    push_rx(8'h21); push_rx(8'h22); push_rx(8'h23);
    @(negedge clk); rx_valid = 1; rx_data = 8'h44; out_ready = 1;
    chk("R7", "head before pair", int'(out_data), 8'h21);
    @(negedge clk); rx_valid = 0; out_ready = 0;
    chk("R7", "count after pair", int'(count), 3);
    pop_chk("R7", 8'h22); pop_chk("R7", 8'h23); pop_chk("R7", 8'h44);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 5; i++) push_rx(8'(i + 8'h30));
    cfg(1, 0);
    chk("R4", "same mode keeps data", int'(count), 5);
    cfg(1, 1);
    chk("R5", "clear empties", int'(count), 0);
    push_rx(8'h50); push_rx(8'h51);
    chk("R5", "capacity kept after clear", int'(full), 0);
    cfg(0, 0);
    chk("R4", "mode off empties", int'(count), 0);
    push_rx(8'h52);
    chk("R4", "single capacity after switch", int'(full), 1);
    cfg(0, 0);
    chk("R4", "same mode single keeps", int'(count), 1);
    cfg(0, 1);
    chk("R5", "clear ignored when disabled", int'(count), 1);
    cfg(1, 0);
    chk("R4", "mode on empties", int'(count), 0);
  endtask

  task automatic t_prio();
    push_rx(8'h60); push_rx(8'h61);
    @(negedge clk);
    cfg_wr = 1; cfg_en = 1; cfg_clr = 1; rx_valid = 1; rx_data = 8'h62; out_ready = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_clr = 0; rx_valid = 0; out_ready = 0;
    chk("R11", "flush wins", int'(count), 0);
    chk("R11", "data after flush", int'(out_data), 255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_empty_pop();
    t_loop();
    t_fifo();
    t_both();
    t_flush();
    t_prio();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule